// File: doc/BRIEF.md
# Data-Processing ALU with Operand Shifter

This block is the execute stage for register-to-register and register-immediate arithmetic and logic instructions. Each cycle it receives the low 26 bits of an instruction word, the value of the first operand register, the value of the second operand register, and the low byte of a shift-amount register. It also receives the current N, Z, C and V flags.

It builds the second operand in one of two ways:
- from an 8-bit constant rotated by an even amount, or
- from the second register passed through a barrel shifter.

It then applies one of sixteen operations. From these it forms the result, a write-enable for the destination register and the next flag values. All outputs are registered.

Register-file access, condition-code evaluation and status-register moves sit outside the block. A pipeline feeds operand values in and takes the result and the write-enable back to the register file in the following cycle. Flags are packed as [3]=N, [2]=Z, [1]=C, [0]=V on both the input and the output.

Top module: `dp_alu`

## Requirements
- R1: All outputs are registered. Values driven before a rising edge appear on the outputs after that edge and not before it. A synchronous active-high reset clears every output to zero.
- R2: When instr[25]=1, operand 2 is instr[7:0] zero-extended and rotated right by 2*instr[11:8]. The shifter carry is then the incoming C when instr[11:8]=0, and otherwise bit 31 of the rotated value.
- R3: When instr[25]=0, operand 2 is rm_val shifted by the kind given in instr[6:5]: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. With instr[4]=0 the amount is instr[11:7], and the carry is the last bit shifted out.
- R4: With instr[4]=1 the amount is rs_lo. Amounts of 32 or more saturate, with these results:
  - Logical left by 32 gives 0 with C = bit 0; by more than 32 it gives 0 with C=0.
  - Logical right by 32 gives 0 with C = bit 31; by more than 32 it gives 0 with C=0.
  - Arithmetic right by 32 or more fills every bit with bit 31, and C = bit 31.
  - Rotate uses the amount modulo 32. A non-zero multiple of 32 leaves the value unchanged, with C = bit 31.
- R5: A shift amount of zero, whether immediate or taken from the register, passes rm_val through unchanged, and the shifter carry equals the incoming C.
- R6: Opcode instr[24:21] values 0, 1, C, D, E and F give, in order: op1 AND op2, op1 XOR op2, op1 OR op2, op2, op1 AND NOT op2, and NOT op2.
- R7: Opcodes 2 to 7 give, in order:
  - 2: op1-op2
  - 3: op2-op1
  - 4: op1+op2
  - 5: op1+op2+C
  - 6: op1-op2+C-1
  - 7: op2-op1+C-1
- R8: Opcodes 8, 9, A and B compute AND, XOR, op1-op2 and op1+op2 respectively, with we_q=0.
- R9: Every opcode outside 8 to B gives we_q=1.
- R10: When instr[20]=0, flags_q equals the flags_in presented in the same cycle as the instruction.
- R11: When instr[20]=1, N is result bit 31 and Z is set when the result is zero. For the logical opcodes (0, 1, 8, 9, C to F), C is the shifter carry and V keeps its input value.
- R12: When instr[20]=1 and the opcode is arithmetic, C is the adder carry-out and V is signed overflow. For subtraction C=1 means no borrow.
- R13: dst_q and src_q are the destination field instr[15:12] and the first-operand field instr[19:16] of the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 26 | Low instruction bits: operand select, opcode, flag enable, register fields, operand-2 encoding |
| rn_val | input | 32 | First operand value |
| rm_val | input | 32 | Second operand register value |
| rs_lo | input | 8 | Low byte of the shift-amount register |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| res_q | output | 32 | Registered result |
| we_q | output | 1 | Registered destination write-enable |
| dst_q | output | 4 | Registered destination register field |
| src_q | output | 4 | Registered first-operand register field |
| flags_q | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
Every result, the write-enable, the flags and the echoed fields are due exactly one rising edge after the inputs are applied. The logic between input and output registers is purely combinational, so there is no further latency.

The bench changes inputs on a falling edge and compares outputs on the next falling edge, half a period after the capturing edge. One directed case also samples shortly before that edge to show the old value still holds.

Expected values come from a bench model that shifts one bit at a time and does its arithmetic in 64-bit signed and unsigned integers.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // compare-type operations never write the destination
  function automatic logic op_no_write(alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

  // logical operations take C from the shifter and keep V
  function automatic logic op_is_logic(alu_op_e op);
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dp_imm_rot.sv
module dp_imm_rot #(
  parameter int DW    = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [ROT_W-1:0] rot,
  input  logic             cin,
  output logic [DW-1:0]    val,
  output logic             cout
);
  localparam int PAD = DW - IMM_W;

  logic [DW-1:0] base;
  int            amt;

  always_comb begin
    base = {{PAD{1'b0}}, imm};
    amt  = 2 * int'(rot);
    // a left shift by DW yields zero, so rot==0 passes base through
    val  = (base >> amt) | (base << (DW - amt));
    cout = (rot == '0) ? cin : val[DW-1];
  end
endmodule

// File: rtl/dp_bshift.sv
module dp_bshift
  import dp_alu_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] amt,
  input  shift_e        kind,
  input  logic          cin,
  output logic [DW-1:0] dout,
  output logic          cout
);
  localparam int            SHW  = $clog2(DW);
  localparam logic [AW-1:0] DW_A = AW'(DW);

  logic [DW:0]        wl;
  logic [DW:0]        wr;
  logic signed [DW:0] wa;
  logic [AW-1:0]      sat;
  logic [SHW-1:0]     rmod;

  always_comb begin
    sat  = (amt > DW_A) ? DW_A : amt;
    rmod = amt[SHW-1:0];
    // extra bit on the shifted-out side captures the carry
    wl   = {1'b0, din} << amt;
    wr   = {din, 1'b0} >> amt;
    wa   = $signed({din, 1'b0}) >>> sat;
    dout = din;
    cout = cin;
    if (amt != '0) begin
      unique case (kind)
        SH_LSL: begin dout = wl[DW-1:0]; cout = wl[DW];  end
        SH_LSR: begin dout = wr[DW:1];   cout = wr[0];   end
        SH_ASR: begin dout = wa[DW:1];   cout = wa[0];   end
        SH_ROR: begin
          if (rmod == '0) begin
            dout = din;
            cout = din[DW-1];
          end else begin
            dout = (din >> rmod) | (din << (DW - int'(rmod)));
            cout = dout[DW-1];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
  import dp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          c_in,
  input  logic          v_in,
  input  logic          sh_c,
  output logic [DW-1:0] y,
  output nzcv_t         fnew
);
  logic [DW-1:0] ax;
  logic [DW-1:0] bx;
  logic          ci;
  logic [DW:0]   sum;
  logic          ovf;
  logic          arith;

  // adder operand steering: subtraction is x + ~y + carry
  always_comb begin
    ax = a;
    bx = b;
    ci = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin ax = a;  bx = ~b; ci = 1'b1; end
      OP_RSB:         begin ax = b;  bx = ~a; ci = 1'b1; end
      OP_ADC:         begin ax = a;  bx = b;  ci = c_in; end
      OP_SBC:         begin ax = a;  bx = ~b; ci = c_in; end
      OP_RSC:         begin ax = b;  bx = ~a; ci = c_in; end
      default:        begin ax = a;  bx = b;  ci = 1'b0; end
    endcase
    sum = {1'b0, ax} + {1'b0, bx} + {{DW{1'b0}}, ci};
    ovf = (ax[DW-1] == bx[DW-1]) && (sum[DW-1] != ax[DW-1]);
  end

  always_comb begin
    arith = !op_is_logic(op);
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = sum[DW-1:0];
    endcase
    fnew.n = y[DW-1];
    fnew.z = (y == '0);
    fnew.c = arith ? sum[DW] : sh_c;
    fnew.v = arith ? ovf : v_in;
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [25:0]   instr,
  input  logic [DW-1:0] rn_val,
  input  logic [DW-1:0] rm_val,
  input  logic [7:0]    rs_lo,
  input  logic [3:0]    flags_in,
  output logic [DW-1:0] res_q,
  output logic          we_q,
  output logic [3:0]    dst_q,
  output logic [3:0]    src_q,
  output logic [3:0]    flags_q
);
  localparam int IMM_W = 8;
  localparam int ROT_W = 4;
  localparam int AMT_W = 8;
  localparam int SA_W  = 5;

  nzcv_t         fin;
  logic          imm_sel;
  logic          set_f;
  logic          reg_amt;
  alu_op_e       op;
  shift_e        kind;
  logic [AMT_W-1:0] amt;
  logic [DW-1:0] imm_v;
  logic          imm_c;
  logic [DW-1:0] sh_v;
  logic          sh_c;
  logic [DW-1:0] op2;
  logic          op2_c;
  logic [DW-1:0] y;
  nzcv_t         fnew;

  always_comb begin
    fin     = nzcv_t'(flags_in);
    imm_sel = instr[25];
    op      = alu_op_e'(instr[24:21]);
    set_f   = instr[20];
    kind    = shift_e'(instr[6:5]);
    reg_amt = instr[4];
    amt     = reg_amt ? rs_lo : {{(AMT_W-SA_W){1'b0}}, instr[11:7]};
  end

  dp_imm_rot #(.DW(DW), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm  (instr[7:0]),
    .rot  (instr[11:8]),
    .cin  (fin.c),
    .val  (imm_v),
    .cout (imm_c)
  );

  dp_bshift #(.DW(DW), .AW(AMT_W)) u_shf (
    .din  (rm_val),
    .amt  (amt),
    .kind (kind),
    .cin  (fin.c),
    .dout (sh_v),
    .cout (sh_c)
  );

  assign op2   = imm_sel ? imm_v : sh_v;
  assign op2_c = imm_sel ? imm_c : sh_c;

  dp_alu_core #(.DW(DW)) u_core (
    .op   (op),
    .a    (rn_val),
    .b    (op2),
    .c_in (fin.c),
    .v_in (fin.v),
    .sh_c (op2_c),
    .y    (y),
    .fnew (fnew)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      we_q    <= 1'b0;
      dst_q   <= '0;
      src_q   <= '0;
      flags_q <= '0;
    end else begin
      res_q   <= y;
      we_q    <= !op_no_write(op);
      dst_q   <= instr[15:12];
      src_q   <= instr[19:16];
      flags_q <= set_f ? fnew : fin;
    end
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [25:0]   instr,
  input logic [3:0]    flags_in,
  input logic [DW-1:0] res_q,
  input logic          we_q,
  input logic [3:0]    dst_q,
  input logic [3:0]    flags_q
);
  logic is_logic;
  assign is_logic = (instr[23:22] == 2'b00) || (instr[24:23] == 2'b11);

  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (instr[24:23] == 2'b10) |=> !we_q); // R8
  AST_OTHER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (instr[24:23] != 2'b10) |=> we_q); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !instr[20] |=> (flags_q == $past(flags_in))); // R10
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    instr[20] |=> (flags_q[2] == (res_q == '0))); // R11
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    instr[20] |=> (flags_q[3] == res_q[DW-1])); // R11
  AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (rst)
    (instr[20] && is_logic) |=> (flags_q[0] == $past(flags_in[0]))); // R11
  AST_IMM_NO_ROT: assert property (@(posedge clk) disable iff (rst)
    (instr[25] && instr[24:21] == 4'hD && instr[11:8] == 4'h0)
      |=> (res_q == {{(DW-8){1'b0}}, $past(instr[7:0])})); // R2
  AST_DST_FIELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dst_q == $past(instr[15:12]))); // R13
endmodule

bind dp_alu dp_alu_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .instr    (instr),
  .flags_in (flags_in),
  .res_q    (res_q),
  .we_q     (we_q),
  .dst_q    (dst_q),
  .flags_q  (flags_q)
);

// File: tb/test_dp_alu.sv
`timescale 1ns/1ps
module test_dp_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [25:0] instr = '0;
  logic [31:0] rn_val = '0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_lo = '0;
  logic [3:0]  flags_in = '0;
  logic [31:0] res_q;
  logic        we_q;
  logic [3:0]  dst_q;
  logic [3:0]  src_q;
  logic [3:0]  flags_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dp_alu i_dp_alu (
    .clk(clk), .rst(rst), .instr(instr), .rn_val(rn_val), .rm_val(rm_val),
    .rs_lo(rs_lo), .flags_in(flags_in), .res_q(res_q), .we_q(we_q),
    .dst_q(dst_q), .src_q(src_q), .flags_q(flags_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bit-serial reference model
  task automatic model(input logic [25:0] ir, input logic [31:0] a, input logic [31:0] rm,
                       input logic [7:0] rs, input logic [3:0] fl,
                       output logic [31:0] r, output logic we, output logic [3:0] fo);
    logic [31:0] v;
    logic        sc;
    logic        cc;
    int          amt;
    longint      sa, sb, sr;
    longint unsigned ua, ub;
    logic [3:0]  op;
    logic        lg;
    cc = fl[1];
    if (ir[25]) begin
      v = {24'h0, ir[7:0]};
      for (int i = 0; i < 2 * int'(ir[11:8]); i++) v = {v[0], v[31:1]};
      sc = (ir[11:8] == 0) ? cc : v[31];
    end else begin
      amt = ir[4] ? int'(rs) : int'(ir[11:7]);
      v = rm;
      sc = cc;
      for (int i = 0; i < amt; i++) begin
        case (ir[6:5])
          2'b00: begin sc = v[31]; v = {v[30:0], 1'b0}; end
          2'b01: begin sc = v[0];  v = {1'b0, v[31:1]}; end
          2'b10: begin sc = v[0];  v = {v[31], v[31:1]}; end
          default: begin sc = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end
    op = ir[24:21];
    sa = longint'($signed(a)); sb = longint'($signed(v));
    ua = {32'h0, a};           ub = {32'h0, v};
    lg = 1'b1;
    sr = 0;
    fo = fl;
    case (op)
      4'h0, 4'h8: r = a & v;
      4'h1, 4'h9: r = a ^ v;
      4'hC: r = a | v;
      4'hD: r = v;
      4'hE: r = a & ~v;
      4'hF: r = ~v;
      default: begin
        lg = 1'b0;
        case (op)
          4'h2, 4'hA: begin r = a - v; fo[1] = ua >= ub; sr = sa - sb; end
          4'h3: begin r = v - a; fo[1] = ub >= ua; sr = sb - sa; end
          4'h4, 4'hB: begin r = a + v; fo[1] = ((ua + ub) >> 32) != 0; sr = sa + sb; end
          4'h5: begin r = a + v + {31'h0, cc}; fo[1] = ((ua + ub + cc) >> 32) != 0; sr = sa + sb + cc; end
          4'h6: begin r = a - v - {31'h0, !cc}; fo[1] = ua >= ub + !cc; sr = sa - sb - !cc; end
          default: begin r = v - a - {31'h0, !cc}; fo[1] = ub >= ua + !cc; sr = sb - sa - !cc; end
        endcase
        fo[0] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      end
    endcase
    if (lg) fo[1] = sc;
    fo[3] = r[31];
    fo[2] = (r == 0);
    if (!ir[20]) fo = fl;
    we = !(op[3:2] == 2'b10);
  endtask

  // called on a falling edge; checks on the next falling edge
  task automatic run(input string rtag, input string ftag, input logic [25:0] ir,
                     input logic [31:0] a, input logic [31:0] rm, input logic [7:0] rs,
                     input logic [3:0] fl);
    logic [31:0] er;
    logic        ew;
    logic [3:0]  ef;
    instr = ir; rn_val = a; rm_val = rm; rs_lo = rs; flags_in = fl;
    model(ir, a, rm, rs, fl, er, ew, ef);
    @(negedge clk);
    chk({rtag, " result"}, res_q, er);
    chk((ir[24:23] == 2'b10) ? "R8 write-enable" : "R9 write-enable", {31'h0, we_q}, {31'h0, ew});
    chk({ftag, " flags"}, {28'h0, flags_q}, {28'h0, ef});
    chk("R13 fields", {24'h0, dst_q, src_q}, {24'h0, ir[15:12], ir[19:16]});
  endtask

  function automatic logic [25:0] enc_imm(input logic [3:0] op, input logic s,
                                          input logic [3:0] rot, input logic [7:0] k);
    return {1'b1, op, s, 4'h2, 4'h3, rot, k};
  endfunction

  function automatic logic [25:0] enc_reg(input logic [3:0] op, input logic s, input logic [4:0] sa,
                                          input logic [1:0] kind, input logic ramt);
    return {1'b0, op, s, 4'h2, 4'h3, sa, kind, ramt, 4'h4};
  endfunction

  function automatic string rtag_of(input logic [3:0] op);
    if (op[3:2] == 2'b10) return "R8";
    if (op[3:1] == 3'b000 || op[3:2] == 2'b11) return "R6";
    return "R7";
  endfunction

  function automatic string ftag_of(input logic [25:0] ir);
    if (!ir[20]) return "R10";
    if (ir[23:22] == 2'b00 || ir[24:23] == 2'b11) return "R11";
    return "R12";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [25:0] ir;
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk("R1 reset result", res_q, 32'h0);
    chk("R1 reset outputs", {23'h0, we_q, dst_q, src_q, flags_q}, 32'h0);
    rst = 1'b0;

    // latency: new value must not show before the capturing edge
    instr = enc_imm(4'hD, 1'b1, 4'h0, 8'h5A); rn_val = 0; rm_val = 0; rs_lo = 0; flags_in = 0;
    #1;
    chk("R1 before edge", res_q, 32'h0);
    @(negedge clk);
    chk("R1 after edge", res_q, 32'h5A);

    // immediate rotation
    run("R2", "R2", enc_imm(4'hD, 1'b1, 4'h4, 8'hFF), 0, 0, 0, 4'h0);          // 0xFF000000, C=1
    run("R2", "R2", enc_imm(4'hD, 1'b1, 4'h0, 8'h81), 0, 0, 0, 4'h2);          // rot 0 keeps C
    run("R2", "R2", enc_imm(4'h4, 1'b0, 4'hF, 8'h03), 32'h10, 0, 0, 4'h0);     // ror 30
    // immediate shift amounts
    run("R3", "R3", enc_reg(4'hD, 1'b1, 5'd4, 2'b10, 1'b0), 0, 32'h80000010, 0, 4'h0);
    run("R3", "R3", enc_reg(4'hD, 1'b1, 5'd1, 2'b00, 1'b0), 0, 32'hC0000001, 0, 4'h0);
    run("R3", "R3", enc_reg(4'hD, 1'b1, 5'd31, 2'b01, 1'b0), 0, 32'h80000000, 0, 4'h0);
    run("R3", "R3", enc_reg(4'hD, 1'b1, 5'd8, 2'b11, 1'b0), 0, 32'h123456F8, 0, 4'h0);
    // register amounts with saturation
    run("R4", "R4", enc_reg(4'hD, 1'b1, 5'd0, 2'b01, 1'b1), 0, 32'h80000001, 8'd32, 4'h0);
    run("R4", "R4", enc_reg(4'hD, 1'b1, 5'd0, 2'b00, 1'b1), 0, 32'hFFFFFFFF, 8'd32, 4'h0);
    run("R4", "R4", enc_reg(4'hD, 1'b1, 5'd0, 2'b00, 1'b1), 0, 32'hFFFFFFFF, 8'd33, 4'h2);
    run("R4", "R4", enc_reg(4'hD, 1'b1, 5'd0, 2'b10, 1'b1), 0, 32'h80000000, 8'd40, 4'h0);
    run("R4", "R4", enc_reg(4'hD, 1'b1, 5'd0, 2'b11, 1'b1), 0, 32'h8000F00F, 8'd64, 4'h0);
    run("R4", "R4", enc_reg(4'hD, 1'b1, 5'd0, 2'b11, 1'b1), 0, 32'h0000000F, 8'd36, 4'h0);
    // zero amount passes through with incoming C
    run("R5", "R5", enc_reg(4'hD, 1'b1, 5'd0, 2'b01, 1'b0), 0, 32'h80000001, 0, 4'h2);
    run("R5", "R5", enc_reg(4'hD, 1'b1, 5'd0, 2'b10, 1'b1), 0, 32'h00000001, 8'd0, 4'h2);
    // arithmetic flag corners
    run("R7", "R12", enc_reg(4'h2, 1'b1, 5'd0, 2'b00, 1'b0), 32'h55, 32'h55, 0, 4'h0);
    run("R7", "R12", enc_reg(4'h4, 1'b1, 5'd0, 2'b00, 1'b0), 32'h7FFFFFFF, 32'h1, 0, 4'h0);
    run("R7", "R12", enc_reg(4'h7, 1'b1, 5'd0, 2'b00, 1'b0), 32'h5, 32'h3, 0, 4'h0);
    run("R8", "R12", enc_reg(4'hA, 1'b1, 5'd0, 2'b00, 1'b0), 32'h3, 32'h5, 0, 4'h1);
    run("R6", "R11", enc_reg(4'hF, 1'b1, 5'd0, 2'b00, 1'b0), 0, 32'hFFFFFFFF, 0, 4'h3);
    run("R6", "R10", enc_reg(4'hE, 1'b0, 5'd0, 2'b00, 1'b0), 32'hF0F0, 32'hFF00, 0, 4'hA);

    for (int n = 0; n < 600; n++) begin
      ir = 26'($urandom);
      if (n % 4 == 0) ir[11:7] = 5'd0;
      run(rtag_of(ir[24:21]), ftag_of(ir), ir, $urandom, $urandom,
          (n % 3 == 0) ? 8'($urandom_range(0, 70)) : 8'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule